// File: doc/BRIEF.md
# Split Translation Buffer Lookup

This block caches page translations for a 32-bit virtual address space with 512-byte pages. Two direct-mapped arrays are kept side by side. One serves system space, which is the upper half of the address space. The other serves process space, which is the lower half. Each slot holds a page-number tag and a translated entry. The translated entry carries a frame number, eight access enables (a read and a write bit for each of the four privilege modes) and a modified flag.

A lookup presents an address, an access mask and a write flag. In the same cycle the block answers hit or miss and gives the physical address. On a miss, an outside page-table walker installs the entry through the fill port. Software-driven maintenance uses two commands: a flush of the process array alone or of both arrays, and an invalidate of the single slot an address selects. A probe port tells whether a tag is resident for an address, without looking at access rights.

Top module: `xlate_buf`

## Requirements
- R1: Address bit 31 picks the array: 1 selects the system array, 0 selects the process array. Slots with the same index in the two arrays never affect each other.
- R2: The page offset is `addr[8:0]` and the page number is `addr[31:9]`. The slot index is the low log2(DEPTH) bits of the page number. On a hit, `lk_pa` equals `{frame, addr[8:0]}` in the same cycle as the lookup. On a miss, `lk_pa` is zero.
- R3: A lookup hits only when the stored page number equals the requested one and the stored enables share at least one set bit with `lk_acc`. Mask layout: bits 0..3 are the read enables for kernel, executive, supervisor and user; bits 4..7 are the write enables for the same modes in the same order.
- R4: When `lk_wr` is 1, a slot whose modified flag is clear gives a miss, even if the tag and the access check both match.
- R5: The 4-bit protection code given with a fill is decoded as follows, counting modes outward from kernel. Codes 0 and 1 grant nothing. Code 2 grants kernel read and write. Code 3 grants kernel read. Code 4 grants read and write in all four modes. For codes 5..15, reads reach two modes for codes 5..7, three for 8..11 and four for 12..15. Writes reach three, two, one or zero modes when `code[1:0]` is 0, 1, 2 or 3.
- R6: After reset, every slot is invalid: its tag and data are all ones. An invalid slot misses every lookup and every probe, including addresses in the topmost page `32'hFFFFFE00`.
- R7: `pr_present` is 1 exactly when the slot selected by `pr_addr` holds that page number, whatever its access enables.
- R8: `inv_one` invalidates only the slot that `inv_addr` selects, and only in the array chosen by `inv_addr[31]`.
- R9: `flush_proc` invalidates every process slot and leaves the system slots intact. `flush_all` invalidates every slot in both arrays.
- R10: A fill takes effect at the next clock edge and is visible from the following cycle. When an invalidate or flush clears the same slot in the same cycle, the clear wins and the fill is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Lookup virtual address |
| lk_acc | input | 8 | Requested access mask (R3 layout) |
| lk_wr | input | 1 | Lookup is a write |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PFN_W+9 | Physical address, zero on miss |
| pr_addr | input | 32 | Probe virtual address |
| pr_present | output | 1 | Tag resident for probe address |
| fl_en | input | 1 | Install an entry |
| fl_addr | input | 32 | Virtual address of the entry being installed |
| fl_prot | input | 4 | Protection code of the entry |
| fl_pfn | input | PFN_W | Frame number of the entry |
| fl_mod | input | 1 | Modified flag of the entry |
| inv_one | input | 1 | Invalidate one slot |
| inv_addr | input | 32 | Address selecting the slot to invalidate |
| flush_proc | input | 1 | Invalidate all process slots |
| flush_all | input | 1 | Invalidate all slots |

## Verification
The properties assume that the inputs change only between clock edges and that the walker does nothing while reset is active. The fill-visibility property assumes that no clear command is issued in the same cycle as the fill it checks. The bench meets these assumptions as follows. It changes every input on the falling edge and holds all commands low during reset. It raises a fill together with a clear only in the directed priority cases, and those cases fall outside that property's antecedent.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 9;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W + 1;   // extra bit keeps all-ones out of reach

  // mask of n modes, counting outward from kernel
  function automatic logic [3:0] mode_span(input logic [2:0] n);
    case (n)
      3'd0:    mode_span = 4'b0000;
      3'd1:    mode_span = 4'b0001;
      3'd2:    mode_span = 4'b0011;
      3'd3:    mode_span = 4'b0111;
      default: mode_span = 4'b1111;
    endcase
  endfunction

  // protection code -> {write[3:0], read[3:0]}
  function automatic logic [7:0] prot_decode(input logic [3:0] code);
    logic [2:0] rd_n, wr_n;
    if (code < 4'd2) begin
      rd_n = 3'd0; wr_n = 3'd0;
    end else if (code == 4'd2) begin
      rd_n = 3'd1; wr_n = 3'd1;
    end else if (code == 4'd3) begin
      rd_n = 3'd1; wr_n = 3'd0;
    end else if (code == 4'd4) begin
      rd_n = 3'd4; wr_n = 3'd4;
    end else begin
      rd_n = (code < 4'd8) ? 3'd2 : (code < 4'd12) ? 3'd3 : 3'd4;
      wr_n = 3'd3 - {1'b0, code[1:0]};
    end
    prot_decode = {mode_span(wr_n), mode_span(rd_n)};
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] addr);
    tag_of = {1'b0, addr[VA_W-1:OFF_W]};
  endfunction
endpackage

// File: rtl/xbuf_array.sv
module xbuf_array #(
  parameter int DEPTH = 64,
  parameter int TAG_W = 24,
  parameter int PFN_W = 21,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all_i,
  input  logic             clr_one_i,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [7:0]       wr_acc,
  input  logic             wr_mod,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output logic [PFN_W-1:0] ra_pfn,
  output logic [7:0]       ra_acc,
  output logic             ra_mod,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PFN_W-1:0] pfn_q [DEPTH];
  logic [7:0]       acc_q [DEPTH];
  logic             mod_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n || clr_all_i || (clr_one_i && clr_idx == IDX_W'(i))) begin
        tag_q[i] <= '1;
        pfn_q[i] <= '1;
        acc_q[i] <= '1;
        mod_q[i] <= 1'b1;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        tag_q[i] <= wr_tag;
        pfn_q[i] <= wr_pfn;
        acc_q[i] <= wr_acc;
        mod_q[i] <= wr_mod;
      end
    end
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_pfn = pfn_q[ra_idx];
  assign ra_acc = acc_q[ra_idx];
  assign ra_mod = mod_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
endmodule

// File: rtl/xbuf_match.sv
module xbuf_match #(
  parameter int TAG_W = 24
) (
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [7:0]       ent_acc,
  input  logic             ent_mod,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [7:0]       req_acc,
  input  logic             req_wr,
  output logic             tag_ok,
  output logic             acc_ok,
  output logic             mod_ok,
  output logic             hit
);
  always_comb begin
    tag_ok = (ent_tag == req_tag);
    acc_ok = |(ent_acc & req_acc);
    mod_ok = ent_mod || !req_wr;
    hit    = tag_ok && acc_ok && mod_ok;
  end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PFN_W = 21,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      lk_addr,
  input  logic [7:0]       lk_acc,
  input  logic             lk_wr,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_pa,
  input  logic [31:0]      pr_addr,
  output logic             pr_present,
  input  logic             fl_en,
  input  logic [31:0]      fl_addr,
  input  logic [3:0]       fl_prot,
  input  logic [PFN_W-1:0] fl_pfn,
  input  logic             fl_mod,
  input  logic             inv_one,
  input  logic [31:0]      inv_addr,
  input  logic             flush_proc,
  input  logic             flush_all
);
  // index fields of each address port
  logic [IDX_W-1:0] lk_idx, pr_idx, fl_idx, inv_idx;
  assign lk_idx  = lk_addr[OFF_W +: IDX_W];
  assign pr_idx  = pr_addr[OFF_W +: IDX_W];
  assign fl_idx  = fl_addr[OFF_W +: IDX_W];
  assign inv_idx = inv_addr[OFF_W +: IDX_W];

  // bits consumed only in part by this block
  logic unused_addr_bits;
  assign unused_addr_bits = ^{fl_addr[OFF_W-1:0], inv_addr[OFF_W-1:0],
                              inv_addr[30:OFF_W+IDX_W], pr_addr[OFF_W-1:0]};

  logic [7:0] fl_acc;
  assign fl_acc = prot_decode(fl_prot);

  // per-array read results, index 0 = process, 1 = system
  logic [TAG_W-1:0] b_ra_tag [2];
  logic [PFN_W-1:0] b_ra_pfn [2];
  logic [7:0]       b_ra_acc [2];
  logic             b_ra_mod [2];
  logic [TAG_W-1:0] b_rb_tag [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam logic IS_SYS = (g == 1);
    logic clr_all_g, clr_one_g, wr_g;
    assign clr_all_g = flush_all || (flush_proc && !IS_SYS);
    assign clr_one_g = inv_one && (inv_addr[31] == IS_SYS);
    assign wr_g      = fl_en && (fl_addr[31] == IS_SYS);

    xbuf_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all_i (clr_all_g),
      .clr_one_i (clr_one_g),
      .clr_idx   (inv_idx),
      .wr_en     (wr_g),
      .wr_idx    (fl_idx),
      .wr_tag    (tag_of(fl_addr)),
      .wr_pfn    (fl_pfn),
      .wr_acc    (fl_acc),
      .wr_mod    (fl_mod),
      .ra_idx    (lk_idx),
      .ra_tag    (b_ra_tag[g]),
      .ra_pfn    (b_ra_pfn[g]),
      .ra_acc    (b_ra_acc[g]),
      .ra_mod    (b_ra_mod[g]),
      .rb_idx    (pr_idx),
      .rb_tag    (b_rb_tag[g])
    );
  end

  // lookup path: pick the array, then evaluate the match
  logic             lk_sel, pr_sel;
  logic [TAG_W-1:0] sel_tag;
  logic [PFN_W-1:0] sel_pfn;
  logic [7:0]       sel_acc;
  logic             sel_mod;
  assign lk_sel  = lk_addr[31];
  assign pr_sel  = pr_addr[31];
  assign sel_tag = b_ra_tag[lk_sel];
  assign sel_pfn = b_ra_pfn[lk_sel];
  assign sel_acc = b_ra_acc[lk_sel];
  assign sel_mod = b_ra_mod[lk_sel];

  // named match events, visible to the checker
  logic lk_tag_ok, lk_acc_ok, lk_mod_ok, lk_match;
  xbuf_match #(.TAG_W(TAG_W)) u_match (
    .ent_tag (sel_tag),
    .ent_acc (sel_acc),
    .ent_mod (sel_mod),
    .req_tag (tag_of(lk_addr)),
    .req_acc (lk_acc),
    .req_wr  (lk_wr),
    .tag_ok  (lk_tag_ok),
    .acc_ok  (lk_acc_ok),
    .mod_ok  (lk_mod_ok),
    .hit     (lk_match)
  );

  assign lk_hit     = lk_match;
  assign lk_pa      = lk_match ? {sel_pfn, lk_addr[OFF_W-1:0]} : '0;
  assign pr_present = (b_rb_tag[pr_sel] == tag_of(pr_addr));
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     lk_addr,
  input logic            lk_wr,
  input logic            lk_hit,
  input logic [PA_W-1:0] lk_pa,
  input logic [31:0]     pr_addr,
  input logic            pr_present,
  input logic            fl_en,
  input logic [31:0]     fl_addr,
  input logic            fl_mod,
  input logic            inv_one,
  input logic            flush_proc,
  input logic            flush_all
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pr_present && !lk_hit));  // R6
  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0));  // R2
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[8:0] == lk_addr[8:0]));  // R2
  AST_PROBE_COVERS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && pr_addr[31:9] == lk_addr[31:9]) |-> pr_present);  // R7
  AST_CLEAN_WRITE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && fl_en && !fl_mod) && lk_wr
      && lk_addr[31:9] == $past(fl_addr[31:9])) |-> !lk_hit);  // R4
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (!pr_present && !lk_hit));  // R9
  AST_FLUSH_PROC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_proc |=> !(pr_present && !pr_addr[31]));  // R9
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && fl_en && !inv_one && !flush_proc && !flush_all)
      && pr_addr[31:9] == $past(fl_addr[31:9])) |-> pr_present);  // R10
endmodule

bind xlate_buf xlate_buf_chk #(.PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_addr    (lk_addr),
  .lk_wr      (lk_wr),
  .lk_hit     (lk_hit),
  .lk_pa      (lk_pa),
  .pr_addr    (pr_addr),
  .pr_present (pr_present),
  .fl_en      (fl_en),
  .fl_addr    (fl_addr),
  .fl_mod     (fl_mod),
  .inv_one    (inv_one),
  .flush_proc (flush_proc),
  .flush_all  (flush_all)
);

// File: tb/xlate_buf_tb.sv
module xlate_buf_tb_top;
  localparam int PFN_W = 21;
  localparam int PA_W  = PFN_W + 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      lk_addr = '0;
  logic [7:0]       lk_acc = '0;
  logic             lk_wr = 1'b0;
  logic             lk_hit;
  logic [PA_W-1:0]  lk_pa;
  logic [31:0]      pr_addr = '0;
  logic             pr_present;
  logic             fl_en = 1'b0;
  logic [31:0]      fl_addr = '0;
  logic [3:0]       fl_prot = '0;
  logic [PFN_W-1:0] fl_pfn = '0;
  logic             fl_mod = 1'b0;
  logic             inv_one = 1'b0;
  logic [31:0]      inv_addr = '0;
  logic             flush_proc = 1'b0;
  logic             flush_all = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xlate_buf #(.DEPTH(64), .PFN_W(PFN_W)) dut_i (.*);

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a, input logic [3:0] p,
                      input logic [PFN_W-1:0] f, input logic m);
    @(negedge clk);
    fl_addr = a; fl_prot = p; fl_pfn = f; fl_mod = m; fl_en = 1'b1;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic [7:0] acc,
                      input logic w, input logic eh, input logic [PA_W-1:0] epa);
    @(negedge clk);
    lk_addr = a; lk_acc = acc; lk_wr = w;
    #1;
    chk(req, 32'(lk_hit), 32'(eh));
    chk(req, 32'(lk_pa), 32'(epa));
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic e);
    @(negedge clk);
    pr_addr = a;
    #1;
    chk(req, 32'(pr_present), 32'(e));
  endtask

  // {addr, acc, wr, hit, pa}; acc bits 0..3 read K,E,S,U, 4..7 write K,E,S,U
  localparam logic [71:0] VEC [19] = '{
    {32'h0000_1234, 8'h08, 1'b0, 1'b1, 30'h0002_4634},  // R2 R5 code4 user read
    {32'h0000_1234, 8'h80, 1'b1, 1'b1, 30'h0002_4634},  // R4 modified set
    {32'h8000_04F0, 8'h01, 1'b0, 1'b1, 30'h0008_ACF0},  // R1 system array
    {32'h8000_04F0, 8'h02, 1'b0, 1'b0, 30'h0},          // R5 code3 exec denied
    {32'h8000_04F0, 8'h10, 1'b1, 1'b0, 30'h0},          // R5 code3 no write
    {32'h0000_05FF, 8'h08, 1'b0, 1'b1, 30'h000F_13FF},  // R1 same index, process
    {32'h0000_05FF, 8'h10, 1'b1, 1'b0, 30'h0},          // R5 code15 no write
    {32'h4000_3010, 8'h10, 1'b1, 1'b1, 30'h0015_7810},  // R5 code6 kernel write
    {32'h4000_3010, 8'h20, 1'b1, 1'b0, 30'h0},          // R5 code6 exec write denied
    {32'h4000_3010, 8'h02, 1'b0, 1'b1, 30'h0015_7810},  // R5 code6 exec read
    {32'h4000_3010, 8'h04, 1'b0, 1'b0, 30'h0},          // R5 code6 super read denied
    {32'h0004_1234, 8'h01, 1'b0, 1'b0, 30'h0},          // R3 tag mismatch same index
    {32'h8000_1234, 8'h01, 1'b0, 1'b0, 30'h0},          // R1 empty system slot
    {32'h0000_0A08, 8'h80, 1'b1, 1'b0, 30'h0},          // R4 clean entry write miss
    {32'h0000_0A08, 8'h08, 1'b0, 1'b1, 30'h0000_2208},  // R4 clean entry read hit
    {32'h0000_0C00, 8'hFF, 1'b0, 1'b0, 30'h0},          // R5 code0 nothing
    {32'h0000_0E44, 8'h01, 1'b0, 1'b1, 30'h0000_4444},  // R5 code2 kernel read
    {32'h0000_0E44, 8'h10, 1'b1, 1'b1, 30'h0000_4444},  // R5 code2 kernel write
    {32'h0000_0E44, 8'h0E, 1'b0, 1'b0, 30'h0}           // R3 no overlap
  };

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: empty after reset, including the top page
    look("R6 top page", 32'hFFFF_FE00, 8'hFF, 1'b0, 1'b0, '0);
    probe("R6 top page probe", 32'hFFFF_FE00, 1'b0);
    probe("R6 zero page probe", 32'h0000_0000, 1'b0);

    fill(32'h0000_1200, 4'd4,  21'h00123, 1'b1);
    fill(32'h8000_0400, 4'd3,  21'h00456, 1'b0);
    fill(32'h0000_0400, 4'd15, 21'h00789, 1'b0);
    fill(32'h4000_3000, 4'd6,  21'h00ABC, 1'b1);
    fill(32'h0000_0A00, 4'd4,  21'h00011, 1'b0);
    fill(32'h0000_0C00, 4'd0,  21'h00033, 1'b1);
    fill(32'h0000_0E00, 4'd2,  21'h00022, 1'b1);

    for (int i = 0; i < 19; i++)
      look("R3 vector", VEC[i][71:40], VEC[i][39:32], VEC[i][31], VEC[i][30], VEC[i][29:0]);

    // R7: presence ignores access rights
    probe("R7 code0 present", 32'h0000_0C10, 1'b1);
    probe("R7 system present", 32'h8000_04F0, 1'b1);
    probe("R7 absent page", 32'h0004_0400, 1'b0);

    // R10: not visible in fill cycle, visible after the edge
    @(negedge clk);
    fl_addr = 32'h0000_1400; fl_prot = 4'd4; fl_pfn = 21'h00055; fl_mod = 1'b1; fl_en = 1'b1;
    pr_addr = 32'h0000_1400;
    #1 chk("R10 before edge", 32'(pr_present), 32'd0);
    @(negedge clk);
    fl_en = 1'b0;
    #1 chk("R10 after edge", 32'(pr_present), 32'd1);

    // R8: single invalidate touches only its own array and slot
    @(negedge clk); inv_addr = 32'h0000_0400; inv_one = 1'b1;
    @(negedge clk); inv_one = 1'b0;
    probe("R8 process slot gone", 32'h0000_0400, 1'b0);
    look("R8 system twin kept", 32'h8000_04F0, 8'h01, 1'b0, 1'b1, 30'h0008_ACF0);
    look("R8 other slot kept", 32'h0000_1234, 8'h08, 1'b0, 1'b1, 30'h0002_4634);

    // R10: clear wins over fill on same slot; different slot fill survives
    @(negedge clk);
    fl_addr = 32'h0000_2000; fl_prot = 4'd4; fl_pfn = 21'h00066; fl_mod = 1'b1; fl_en = 1'b1;
    inv_addr = 32'h0000_2000; inv_one = 1'b1;
    @(negedge clk); fl_en = 1'b0; inv_one = 1'b0;
    probe("R10 clear beats fill", 32'h0000_2000, 1'b0);
    @(negedge clk);
    fl_addr = 32'h0000_2200; fl_en = 1'b1; inv_addr = 32'h0000_1400; inv_one = 1'b1;
    @(negedge clk); fl_en = 1'b0; inv_one = 1'b0;
    probe("R10 fill other slot", 32'h0000_2200, 1'b1);
    probe("R8 invalidated", 32'h0000_1400, 1'b0);

    // R9: process flush keeps system entries
    @(negedge clk); flush_proc = 1'b1;
    @(negedge clk); flush_proc = 1'b0;
    probe("R9 process flushed", 32'h0000_1200, 1'b0);
    look("R9 process miss", 32'h4000_3010, 8'h02, 1'b0, 1'b0, '0);
    look("R9 system kept", 32'h8000_04F0, 8'h01, 1'b0, 1'b1, 30'h0008_ACF0);

    // R9: full flush, a fill in the same cycle is dropped
    @(negedge clk);
    flush_all = 1'b1; fl_addr = 32'h8000_0600; fl_en = 1'b1;
    @(negedge clk); flush_all = 1'b0; fl_en = 1'b0;
    probe("R9 system flushed", 32'h8000_04F0, 1'b0);
    probe("R9 fill dropped", 32'h8000_0600, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule